// File: doc/BRIEF.md
# Fall-Through Read Output Stage

This block sits on the read side of a dual-clock FIFO, between the storage array and the read port. In fall-through mode it fetches the oldest stored word onto the data outputs without waiting for a request. It also drives an active-low ready flag that is low whenever the outputs hold a word the consumer has not yet taken. In standard mode the same flag pin acts as an active-low empty indication instead, and a word reaches the outputs only after an explicit read.

The storage array, the write side and the pointer synchronizers are outside this block. The storage is represented by a word count, a head-of-queue data bus that is valid whenever the count is nonzero, and a pop strobe from this block. The count is registered before it is used, so the stage never pops an empty store even when the count arrives late. The operating mode is latched only while synchronous reset is held.

Top module: `rdfwft_out_stage`

## Requirements
- R1: In fall-through mode (mode input 1 at reset), if the store count turns nonzero before rising edge k while the outputs hold no word, that word is on the data outputs and the flag pin is low after edge k+2, and the flag is still high after edges k and k+1. The flag is low exactly while an untaken word is on the outputs.
- R2: In fall-through mode, the flag stays low after the edge that loads the last stored word. It goes high only at an edge where read enable is low while the flag is low and no further word can be fetched.
- R3: In fall-through mode, the data outputs change only when a new word is loaded. After the last word has been taken, they keep showing it.
- R4: In fall-through mode, read enable low while the flag is high pops nothing and leaves the flag and the data unchanged.
- R5: In fall-through mode, a read at an edge where another stored word is fetchable loads that word at the same edge and keeps the flag low, so one word is delivered per cycle.
- R6: In standard mode (mode input 0 at reset), the flag pin low means empty. It rises after the second edge following the count turning nonzero from zero, and it falls at the edge of the read that removes the final word.
- R7: In standard mode, an edge with read enable low and the flag high pops one word, and that word is on the data outputs after the edge. Otherwise the data outputs hold their value.
- R8: In standard mode, read enable low while the flag is low pops nothing and leaves the data unchanged.
- R9: The mode input is sampled only while reset is low. Changing it afterwards has no effect until the next reset.
- R10: After synchronous reset (reset low at a rising edge), the data outputs are zero and the pop strobe is low. The flag pin is high in fall-through mode and low in standard mode.
- R11: The pop strobe is high only when the store count is nonzero, and only at the edges described in R1, R5 and R7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_rd | input | 1 | Read clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| mode_sel_i | input | 1 | 1 selects fall-through, 0 standard; sampled during reset |
| rd_en_n | input | 1 | Read enable, active low |
| st_count_i | input | CNT_W | Words currently held by the storage |
| st_data_i | input | DATA_W | Head word of the storage, valid when count is nonzero |
| st_pop_o | output | 1 | Removes the head word at the next rising edge |
| rd_data_o | output | DATA_W | Registered output data |
| flag_n_o | output | 1 | Ready flag (fall-through) or empty flag (standard), active low |

## Verification
The hardest situation to reach is the edge where the final stored word is loaded or read in the same cycle that a new write arrives. There, the registered count lags the store, and the flag must neither drop early nor let a pop reach an empty store. The stimulus gets there with long runs of back-to-back reads against sparse single-word writes, with write bursts timed to land one or two cycles after the store drains. This is done in both modes, while the mode input is toggled outside reset so that any leak of it is visible at the flag latency.

// File: rtl/rdfwft_pkg.sv
package rdfwft_pkg;

    typedef enum logic [0:0] {
        MODE_STD  = 1'b0,
        MODE_FALL = 1'b1
    } mode_e;

    // store-visibility pipeline: first stage sees a nonempty store,
    // second stage confirms it for one more edge
    typedef struct packed {
        logic avail;
        logic armed;
    } avail_state_t;

    typedef struct packed {
        mode_e mode;
        logic  rdy_n;
    } ctrl_state_t;

endpackage

// File: rtl/rdfwft_avail.sv
module rdfwft_avail #(
    parameter int CNT_W = 6
) (
    input  logic             clk_rd,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] st_count_i,
    input  logic             pop_i,
    output logic             avail_o,
    output logic             armed_o
);
    import rdfwft_pkg::*;

    localparam logic [CNT_W-1:0] ONE_WORD = CNT_W'(1);

    avail_state_t av_d, av_q;
    logic         left_after_pop;

    always_comb begin
        // words remain once this edge's pop (if any) is taken away
        left_after_pop = (st_count_i != '0) && !(pop_i && (st_count_i == ONE_WORD));
        av_d = av_q;
        if (!rst_n) begin
            av_d = '0;
        end else begin
            av_d.avail = left_after_pop;
            av_d.armed = av_q.avail && left_after_pop;
        end
    end

    always_ff @(posedge clk_rd) begin
        av_q <= av_d;
    end

    assign avail_o = av_q.avail;
    assign armed_o = av_q.armed;

    // R11
    no_empty_pop_chk: assert property (@(posedge clk_rd) disable iff (!rst_n)
        pop_i |-> (st_count_i != '0));

    // R6
    armed_rise_chk: assert property (@(posedge clk_rd) disable iff (!rst_n)
        $rose(av_q.armed) |-> $past(av_q.avail));

endmodule

// File: rtl/rdfwft_ctrl.sv
module rdfwft_ctrl (
    input  logic clk_rd,
    input  logic rst_n,
    input  logic mode_sel_i,
    input  logic rd_en_n,
    input  logic armed_i,
    output logic pop_o,
    output logic flag_n_o
);
    import rdfwft_pkg::*;

    ctrl_state_t st_d, st_q;
    logic        fall_mode;
    logic        real_rd;

    assign fall_mode = (st_q.mode == MODE_FALL);

    always_comb begin
        st_d    = st_q;
        real_rd = 1'b0;
        pop_o   = 1'b0;
        if (fall_mode) begin
            real_rd = !rd_en_n && !st_q.rdy_n;
            pop_o   = rst_n && armed_i && (st_q.rdy_n || !rd_en_n);
        end else begin
            real_rd = !rd_en_n && armed_i;
            pop_o   = rst_n && real_rd;
        end

        if (!rst_n) begin
            st_d.mode  = mode_e'(mode_sel_i);
            st_d.rdy_n = 1'b1;
        end else if (fall_mode) begin
            if (pop_o) begin
                st_d.rdy_n = 1'b0;
            end else if (real_rd) begin
                st_d.rdy_n = 1'b1;
            end
        end
    end

    always_ff @(posedge clk_rd) begin
        st_q <= st_d;
    end

    assign flag_n_o = fall_mode ? st_q.rdy_n : armed_i;

    // R2
    ready_rise_chk: assert property (@(posedge clk_rd) disable iff (!rst_n)
        (fall_mode && $rose(st_q.rdy_n)) |-> $past(!rd_en_n));

    // R7
    std_pop_chk: assert property (@(posedge clk_rd) disable iff (!rst_n)
        (!fall_mode && pop_o) |-> !rd_en_n);

    // R9
    mode_hold_chk: assert property (@(posedge clk_rd) disable iff (!rst_n)
        $past(rst_n) |-> $stable(st_q.mode));

endmodule

// File: rtl/rdfwft_dreg.sv
module rdfwft_dreg #(
    parameter int DATA_W = 9
) (
    input  logic              clk_rd,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [DATA_W-1:0] din_i,
    output logic [DATA_W-1:0] q_o
);
    logic [DATA_W-1:0] word_d, word_q;

    always_comb begin
        word_d = word_q;
        if (!rst_n) begin
            word_d = '0;
        end else if (load_i) begin
            word_d = din_i;
        end
    end

    always_ff @(posedge clk_rd) begin
        word_q <= word_d;
    end

    assign q_o = word_q;

    // R3
    data_hold_chk: assert property (@(posedge clk_rd) disable iff (!rst_n)
        !load_i |=> $stable(word_q));

endmodule

// File: rtl/rdfwft_out_stage.sv
module rdfwft_out_stage #(
    parameter int DATA_W = 9,
    parameter int CNT_W  = 6
) (
    input  logic              clk_rd,
    input  logic              rst_n,
    input  logic              mode_sel_i,
    input  logic              rd_en_n,
    input  logic [CNT_W-1:0]  st_count_i,
    input  logic [DATA_W-1:0] st_data_i,
    output logic              st_pop_o,
    output logic [DATA_W-1:0] rd_data_o,
    output logic              flag_n_o
);
    logic avail;
    logic armed;
    logic pop;

    rdfwft_avail #(.CNT_W(CNT_W)) avail_i (
        .clk_rd     (clk_rd),
        .rst_n      (rst_n),
        .st_count_i (st_count_i),
        .pop_i      (pop),
        .avail_o    (avail),
        .armed_o    (armed)
    );

    rdfwft_ctrl ctrl_i (
        .clk_rd     (clk_rd),
        .rst_n      (rst_n),
        .mode_sel_i (mode_sel_i),
        .rd_en_n    (rd_en_n),
        .armed_i    (armed),
        .pop_o      (pop),
        .flag_n_o   (flag_n_o)
    );

    rdfwft_dreg #(.DATA_W(DATA_W)) dreg_i (
        .clk_rd (clk_rd),
        .rst_n  (rst_n),
        .load_i (pop),
        .din_i  (st_data_i),
        .q_o    (rd_data_o)
    );

    assign st_pop_o = pop;

    // R10
    reset_quiet_chk: assert property (@(posedge clk_rd)
        !rst_n |=> (rd_data_o == '0) && !st_pop_o);

    logic unused_avail;
    assign unused_avail = avail;

endmodule

// File: tb/rdfwft_out_stage_tb.sv
module rdfwft_out_stage_tb_top;
    localparam int DATA_W = 9;
    localparam int CNT_W  = 6;

    logic              clk_rd = 1'b0;
    logic              rst_n  = 1'b0;
    logic              mode_sel_i = 1'b1;
    logic              rd_en_n = 1'b1;
    logic [CNT_W-1:0]  st_count_i = '0;
    logic [DATA_W-1:0] st_data_i = '0;
    logic              st_pop_o;
    logic [DATA_W-1:0] rd_data_o;
    logic              flag_n_o;

    rdfwft_out_stage #(.DATA_W(DATA_W), .CNT_W(CNT_W)) dut_i (
        .clk_rd     (clk_rd),
        .rst_n      (rst_n),
        .mode_sel_i (mode_sel_i),
        .rd_en_n    (rd_en_n),
        .st_count_i (st_count_i),
        .st_data_i  (st_data_i),
        .st_pop_o   (st_pop_o),
        .rd_data_o  (rd_data_o),
        .flag_n_o   (flag_n_o)
    );

    always #10 clk_rd = ~clk_rd;

    int compared = 0;
    int mismatched = 0;
    bit done = 0;
    int next_word = 1;
    int stor[$];

    // behavioural reference state
    bit m_fall, m_seen, m_conf, m_rdy_n;
    int m_q;

    task automatic chk(input string tag, input int act, input int exp);
        compared++;
        if (act != exp) begin
            mismatched++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic drive_store();
        st_count_i = CNT_W'(stor.size());
        st_data_i  = (stor.size() != 0) ? DATA_W'(stor[0]) : '0;
    endtask

    function automatic bit ref_pop(input bit rd);
        if (!rst_n) return 0;
        if (m_fall) return m_conf && (m_rdy_n || !rd);
        return m_conf && !rd;
    endfunction

    function automatic int ref_flag();
        return m_fall ? int'(m_rdy_n) : int'(m_conf);
    endfunction

    task automatic tick(input bit rd, input int nw);
        bit exp_pop, got_pop, rst_now, remain;
        int cnt0, head0;
        rd_en_n = rd;
        for (int i = 0; i < nw; i++) begin
            if (stor.size() < 40) begin
                stor.push_back(next_word & 9'h1ff);
                next_word++;
            end
        end
        drive_store();
        #1;
        exp_pop = ref_pop(rd);
        got_pop = st_pop_o;
        chk("R11 pop", int'(got_pop), int'(exp_pop));
        cnt0 = stor.size();
        head0 = (cnt0 != 0) ? stor[0] : 0;
        rst_now = !rst_n;
        @(posedge clk_rd);
        if (rst_now) begin
            m_fall = mode_sel_i; m_seen = 0; m_conf = 0; m_rdy_n = 1; m_q = 0;
        end else begin
            remain = (cnt0 - int'(exp_pop)) > 0;
            if (m_fall) begin
                if (exp_pop) begin m_q = head0; m_rdy_n = 0; end
                else if (!rd && !m_rdy_n) m_rdy_n = 1;
            end else if (exp_pop) begin
                m_q = head0;
            end
            m_conf = m_seen && remain;
            m_seen = remain;
        end
        #1;
        if (got_pop === 1'b1 && stor.size() != 0) void'(stor.pop_front());
        drive_store();
        @(negedge clk_rd);
        chk(m_fall ? "R1 flag" : "R6 flag", int'(flag_n_o), ref_flag());
        chk(m_fall ? "R3 data" : "R7 data", int'(rd_data_o), m_q);
    endtask

    task automatic do_reset(input bit md);
        mode_sel_i = md;
        rst_n = 0;
        tick(1, 0); tick(1, 0); tick(1, 0);
        rst_n = 1;
        // R10
        chk("R10 data", int'(rd_data_o), 0);
        chk("R10 flag", int'(flag_n_o), md ? 1 : 0);
        chk("R10 pop", int'(st_pop_o), 0);
    endtask

    task automatic rand_run(input int n);
        for (int i = 0; i < n; i++) begin
            if (($urandom % 16) == 0) mode_sel_i = ~mode_sel_i; // R9
            tick(($urandom % 3) == 0, (($urandom % 5) == 0) ? int'($urandom % 4) : 0);
        end
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            mismatched++;
            compared++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        int w0, w_last;
        @(negedge clk_rd);
        // ---------------- fall-through mode ----------------
        do_reset(1'b1);
        stor.delete();
        w0 = next_word;
        tick(1, 1);
        chk("R1 latency edge k", int'(flag_n_o), 1);
        tick(1, 0);
        chk("R1 latency edge k+1", int'(flag_n_o), 1);
        tick(1, 0);
        chk("R1 latency edge k+2 flag", int'(flag_n_o), 0);
        chk("R1 latency edge k+2 data", int'(rd_data_o), w0);
        tick(1, 0); tick(1, 0);
        chk("R2 last word keeps flag low", int'(flag_n_o), 0);
        tick(0, 0);
        chk("R2 real read raises flag", int'(flag_n_o), 1);
        chk("R3 last word held", int'(rd_data_o), w0);
        tick(0, 0); tick(0, 0);
        chk("R4 ignored read flag", int'(flag_n_o), 1);
        chk("R4 ignored read data", int'(rd_data_o), w0);
        chk("R4 store untouched", stor.size(), 0);
        w0 = next_word;
        tick(1, 4); tick(1, 0); tick(1, 0);
        chk("R5 first of burst", int'(rd_data_o), w0);
        for (int i = 1; i < 4; i++) begin
            tick(0, 0);
            chk("R5 back-to-back flag", int'(flag_n_o), 0);
            chk("R5 back-to-back data", int'(rd_data_o), w0 + i);
        end
        w_last = w0 + 3;
        tick(0, 0);
        chk("R2 drained flag", int'(flag_n_o), 1);
        chk("R3 drained data", int'(rd_data_o), w_last);
        // R9: mode change outside reset keeps fall-through latency
        mode_sel_i = 1'b0;
        w0 = next_word;
        tick(1, 1); tick(1, 0);
        chk("R9 mode ignored k+1", int'(flag_n_o), 1);
        tick(1, 0);
        chk("R9 mode ignored k+2", int'(flag_n_o), 0);
        chk("R9 mode ignored data", int'(rd_data_o), w0);
        mode_sel_i = 1'b1;
        rand_run(400);

        // ---------------- standard mode ----------------
        do_reset(1'b0);
        stor.delete();
        drive_store();
        tick(1, 0);
        w0 = next_word;
        tick(1, 1);
        chk("R6 flag after edge k", int'(flag_n_o), 0);
        tick(1, 0);
        chk("R6 flag after edge k+1", int'(flag_n_o), 1);
        chk("R7 no read no data", int'(rd_data_o), 0);
        tick(0, 0);
        chk("R7 read data", int'(rd_data_o), w0);
        chk("R6 final read empties", int'(flag_n_o), 0);
        tick(0, 0); tick(0, 0);
        chk("R8 empty read data", int'(rd_data_o), w0);
        chk("R8 empty read store", stor.size(), 0);
        mode_sel_i = 1'b1;
        w0 = next_word;
        tick(1, 1); tick(1, 0);
        chk("R9 std mode kept flag", int'(flag_n_o), 1);
        chk("R9 std mode kept data", int'(rd_data_o), w0 - 1);
        rand_run(400);

        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule